// File: doc/BRIEF.md
# Channel Status Capture with Change Interrupt

This block sits behind a biphase audio decoder. For each decoded subframe it receives one channel-status bit, a flag saying whether the subframe belongs to channel A or channel B, and a marker for the first frame of a 192-frame status block. It assembles the leading forty status bits of each channel into a private shadow register. It publishes the assembled word to a visible register only once the fortieth bit of the block has arrived.

Each time a block completes, the freshly assembled word is compared with the word currently visible. If they differ and interrupts are enabled, a sticky interrupt flag is raised. Software-side logic clears the flag with a single-cycle pulse. Status bits past the fortieth in a block are dropped. A block that restarts early throws its partial contents away.

Top module: `chstat_capture`

## Requirements
- R1: During and right after reset, `stat_a` and `stat_b` are all zeros and `irq` is low.
- R2: Once a block completes, bit k of `stat_a` holds the status bit of the k-th channel-A subframe of that block. Index 0 is the first channel-A subframe at or after the block-start marker.
- R3: Subframes with `sub_chan`=0 feed only `stat_a`, and subframes with `sub_chan`=1 feed only `stat_b`. Each channel counts its own bit index.
- R4: A visible register changes only on the clock edge that takes in that channel's bit 39 of a block. Until then it keeps its previous word, so no partial block is ever visible.
- R5: Status bits at index 40 and above within a block, up to the next block-start marker, have no effect on either register.
- R6: A block-start marker that arrives before bit 39 discards the partial shadow. Collection then restarts at index 0.
- R7: After reset, subframes that arrive before the first block-start marker have no effect.
- R8: When a completed word differs from the visible word and `irq_en` is high in that cycle, `irq` is high from the next cycle. A completed word equal to the visible word does not set `irq`.
- R9: With `irq_en` low, completed blocks still update the registers but do not set `irq`.
- R10: `irq` stays high until a cycle with `irq_clr` high. If a clear and a new set fall in the same cycle, `irq` stays high.
- R11: Cycles with `sub_vld` low have no effect, whatever `sub_chan`, `blk_start` and `stat_bit` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_vld | input | 1 | A decoded subframe is presented this cycle |
| sub_chan | input | 1 | Channel of the subframe: 0 is A, 1 is B |
| blk_start | input | 1 | Subframe belongs to frame 0 of a status block (qualified by sub_vld) |
| stat_bit | input | 1 | Channel-status bit of the subframe |
| irq_en | input | 1 | Allows a status change to set the interrupt |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt |
| stat_a | output | 40 | Last completed status bits 0..39 of channel A |
| stat_b | output | 40 | Last completed status bits 0..39 of channel B |
| irq | output | 1 | Sticky status-change interrupt |

## Verification
The bound checker watches several properties on every cycle. A register only moves after a subframe of its own channel. Every register move follows a detected difference. A move while enabled always leaves the interrupt raised. The interrupt never rises without the enable, holds until cleared, and falls after a clear that has no competing set. What only the bench scenarios can show is which bits end up where: bit ordering from the block-start marker, discarding of early-restarted and pre-start data, the dropping of bits past index 39, the equal-word case that must stay silent, and the same-cycle clear and set.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
   localparam int CHSTAT_BITS_DEF  = 40;
   localparam int CHSTAT_BLOCK_DEF = 192;
   localparam int CHSTAT_LANES     = 2;

   typedef enum logic {
      CHAN_A = 1'b0,
      CHAN_B = 1'b1
   } chan_e;
endpackage

// File: rtl/chstat_lane.sv
module chstat_lane #(
   parameter int STAT_BITS = chstat_pkg::CHSTAT_BITS_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit,
   input  logic                 restart,
   input  logic                 bit_in,
   output logic [STAT_BITS-1:0] vis,
   output logic                 diff
);
   localparam int IDXW = $clog2(STAT_BITS + 1);
   localparam logic [IDXW-1:0] IDX_DONE = IDXW'(STAT_BITS);
   localparam logic [IDXW-1:0] IDX_LAST = IDXW'(STAT_BITS - 1);
   localparam logic [IDXW-1:0] IDX_ONE  = IDXW'(1);

   logic [IDXW-1:0]      idx;
   logic [STAT_BITS-1:0] shadow;
   logic [STAT_BITS-1:0] merged;
   logic                 collecting;
   logic                 last;

   // idx saturates at IDX_DONE: waiting for a block start or past the kept bits
   assign collecting = hit & ~restart & (idx < IDX_DONE);
   assign last       = collecting & (idx == IDX_LAST);

   always_comb begin
      merged = shadow;
      for (int k = 0; k < STAT_BITS; k++) begin
         if (idx == IDXW'(k)) merged[k] = bit_in;
      end
   end

   assign diff = last & (merged != vis);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= IDX_DONE;
         shadow <= '0;
         vis    <= '0;
      end else if (restart) begin
         if (hit) begin
            shadow <= {{(STAT_BITS-1){1'b0}}, bit_in};
            idx    <= IDX_ONE;
         end else begin
            shadow <= '0;
            idx    <= '0;
         end
      end else if (collecting) begin
         shadow <= merged;
         idx    <= idx + IDX_ONE;
         if (last) vis <= merged;
      end
   end
endmodule

// File: rtl/chstat_irq.sv
module chstat_irq #(
   parameter int N_LANES = chstat_pkg::CHSTAT_LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LANES-1:0] diff,
   input  logic               en,
   input  logic               clr,
   output logic               irq
);
   logic set_now;
   assign set_now = en & (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= set_now | (irq & ~clr);
   end
endmodule

// File: rtl/chstat_capture.sv
module chstat_capture #(
   parameter int STAT_BITS    = chstat_pkg::CHSTAT_BITS_DEF,
   parameter int BLOCK_FRAMES = chstat_pkg::CHSTAT_BLOCK_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sub_vld,
   input  logic                 sub_chan,
   input  logic                 blk_start,
   input  logic                 stat_bit,
   input  logic                 irq_en,
   input  logic                 irq_clr,
   output logic [STAT_BITS-1:0] stat_a,
   output logic [STAT_BITS-1:0] stat_b,
   output logic                 irq
);
   localparam int N_LANES = chstat_pkg::CHSTAT_LANES;

   if (STAT_BITS < 2 || STAT_BITS > BLOCK_FRAMES) begin : g_bad_cfg
      $error("chstat_capture: STAT_BITS must lie in 2..BLOCK_FRAMES");
   end

   logic                                restart;
   logic [N_LANES-1:0]                  lane_diff;
   logic [N_LANES-1:0][STAT_BITS-1:0]   lane_vis;

   assign restart = sub_vld & blk_start;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      logic lane_hit;
      assign lane_hit = sub_vld & (sub_chan == 1'(g));

      chstat_lane #(.STAT_BITS(STAT_BITS)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (lane_hit),
         .restart (restart),
         .bit_in  (stat_bit),
         .vis     (lane_vis[g]),
         .diff    (lane_diff[g])
      );
   end

   assign stat_a = lane_vis[chstat_pkg::CHAN_A];
   assign stat_b = lane_vis[chstat_pkg::CHAN_B];

   chstat_irq #(.N_LANES(N_LANES)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .diff  (lane_diff),
      .en    (irq_en),
      .clr   (irq_clr),
      .irq   (irq)
   );
endmodule

// File: rtl/chstat_capture_chk.sv
module chstat_capture_chk #(
   parameter int STAT_BITS = 40
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sub_vld,
   input logic                 sub_chan,
   input logic                 irq_en,
   input logic                 irq_clr,
   input logic [STAT_BITS-1:0] stat_a,
   input logic [STAT_BITS-1:0] stat_b,
   input logic                 irq,
   input logic [1:0]           lane_diff
);
   // R3 R11
   a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sub_vld && !sub_chan) |=> $stable(stat_a));
   // R3 R11
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sub_vld && sub_chan) |=> $stable(stat_b));
   // R4
   a_update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_a) |-> $past(lane_diff[0]));
   // R4
   b_update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_b) |-> $past(lane_diff[1]));
   // R8
   a_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(stat_a) && $past(irq_en)) |-> irq);
   // R8
   b_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(stat_b) && $past(irq_en)) |-> irq);
   // R9
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en));
   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   // R10
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_clr && !(irq_en && (|lane_diff))) |=> !irq);
endmodule

bind chstat_capture chstat_capture_chk #(.STAT_BITS(STAT_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sub_vld   (sub_vld),
   .sub_chan  (sub_chan),
   .irq_en    (irq_en),
   .irq_clr   (irq_clr),
   .stat_a    (stat_a),
   .stat_b    (stat_b),
   .irq       (irq),
   .lane_diff (lane_diff)
);

// File: tb/chstat_capture_bench.sv
module chstat_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sub_vld, sub_chan, blk_start, stat_bit, irq_en, irq_clr;
   logic [39:0] stat_a, stat_b;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // bench model state
   logic [39:0] m_sh  [2];
   logic [39:0] m_vis [2];
   int          m_idx [2];
   logic        m_irq;

   always #10 clk = ~clk;

   chstat_capture u_chstat_capture (
      .clk(clk), .rst_n(rst_n), .sub_vld(sub_vld), .sub_chan(sub_chan),
      .blk_start(blk_start), .stat_bit(stat_bit), .irq_en(irq_en),
      .irq_clr(irq_clr), .stat_a(stat_a), .stat_b(stat_b), .irq(irq)
   );

   task automatic chk40(input string tag, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int c = 0; c < 2; c++) begin
         m_sh[c] = '0; m_vis[c] = '0; m_idx[c] = 40;
      end
      m_irq = 1'b0;
   endfunction

   // post-edge state from the requirements
   function automatic void model_step(input logic v, input logic ch, input logic st,
                                      input logic b, input logic clr, input logic en);
      logic set = 1'b0;
      for (int c = 0; c < 2; c++) begin
         logic hit = v && (ch == 1'(c));
         if (v && st) begin
            m_sh[c] = '0;
            if (hit) begin m_sh[c][0] = b; m_idx[c] = 1; end
            else m_idx[c] = 0;
         end else if (hit && m_idx[c] < 40) begin
            m_sh[c][m_idx[c]] = b;
            if (m_idx[c] == 39) begin
               if (m_sh[c] != m_vis[c] && en) set = 1'b1;
               m_vis[c] = m_sh[c];
            end
            m_idx[c]++;
         end
      end
      m_irq = set | (m_irq & ~clr);
   endfunction

   task automatic sub(input logic v, input logic ch, input logic st,
                      input logic b, input logic clr);
      @(negedge clk);
      // R2 R3 R8 per-cycle comparison against the model
      chk40("R2 stat_a model", stat_a, m_vis[0]);
      chk40("R3 stat_b model", stat_b, m_vis[1]);
      chk1("R8 irq model", irq, m_irq);
      sub_vld = v; sub_chan = ch; blk_start = st; stat_bit = b; irq_clr = clr;
      model_step(v, ch, st, b, clr, irq_en);
   endtask

   task automatic flush();
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic send_block(input logic [39:0] a, input logic [39:0] bb,
                             input int f0, input int n, input bit clr_last, input bit gaps);
      for (int f = f0; f < f0 + n; f++) begin
         logic ba = (f < 40) ? a[f]  : 1'($urandom);
         logic bv = (f < 40) ? bb[f] : 1'($urandom);
         if (gaps && ($urandom % 3 == 0))
            sub(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
         sub(1'b1, 1'b0, f == 0, ba, 1'b0);
         if (gaps && ($urandom % 3 == 0))
            sub(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
         sub(1'b1, 1'b1, 1'b0, bv, clr_last && f == 39);
      end
   endtask

   function automatic logic [39:0] rnd40();
      return {8'($urandom), 32'($urandom)};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [39:0] a1, b1, a2, b2, a3, b3, a4, b4, a6, b6, a7, b7;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; sub_vld = 0; sub_chan = 0; blk_start = 0; stat_bit = 0;
      irq_en = 1'b1; irq_clr = 0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1 values during reset
      chk40("R1 stat_a reset", stat_a, '0);
      chk40("R1 stat_b reset", stat_b, '0);
      chk1("R1 irq reset", irq, 1'b0);
      rst_n = 1'b1;

      // R7 traffic before any block start
      send_block(rnd40(), rnd40(), 1, 60, 0, 0);
      flush();
      chk40("R7 stat_a before start", stat_a, '0);
      chk1("R7 irq before start", irq, 1'b0);

      // R2 R3 R8 first full block
      a1 = rnd40() | 40'h1; b1 = ~a1;
      send_block(a1, b1, 0, 192, 0, 0);
      flush();
      chk40("R2 stat_a block1", stat_a, a1);
      chk40("R3 stat_b block1", stat_b, b1);
      chk1("R8 irq after change", irq, 1'b1);

      // R10 clear pulse
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      flush();
      chk1("R10 irq cleared", irq, 1'b0);

      // R4 no partial visibility, independent completion per channel
      a2 = ~a1; b2 = a1;
      send_block(a2, b2, 0, 39, 0, 0);
      flush();
      chk40("R4 stat_a before bit39", stat_a, a1);
      chk40("R4 stat_b before bit39", stat_b, b1);
      sub(1'b1, 1'b0, 1'b0, a2[39], 1'b0);
      flush();
      chk40("R4 stat_a at bit39", stat_a, a2);
      chk40("R4 stat_b still old", stat_b, b1);
      sub(1'b1, 1'b1, 1'b0, b2[39], 1'b0);
      flush();
      chk40("R4 stat_b at bit39", stat_b, b2);
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

      // R8 identical block leaves irq low
      send_block(a2, b2, 0, 192, 0, 0);
      flush();
      chk1("R8 no irq on equal word", irq, 1'b0);

      // R9 disabled interrupt
      irq_en = 1'b0;
      a3 = rnd40(); b3 = rnd40() ^ 40'h80_0000_0000;
      send_block(a3, b3, 0, 192, 0, 0);
      flush();
      chk40("R9 stat_a updated", stat_a, a3);
      chk40("R9 stat_b updated", stat_b, b3);
      chk1("R9 irq stays low", irq, 1'b0);
      irq_en = 1'b1;

      // R6 early restart discards partial
      send_block(rnd40(), rnd40(), 0, 25, 0, 0);
      a4 = ~a3; b4 = ~b3;
      send_block(a4, b4, 0, 20, 0, 0);
      flush();
      chk40("R6 partial not visible", stat_a, a3);
      send_block(a4, b4, 20, 172, 0, 0);
      flush();
      chk40("R6 stat_a restarted block", stat_a, a4);
      chk40("R6 stat_b restarted block", stat_b, b4);
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

      // R5 bits past index 39 ignored
      send_block(rnd40(), rnd40(), 40, 300, 0, 0);
      flush();
      chk40("R5 stat_a unchanged", stat_a, a4);
      chk40("R5 stat_b unchanged", stat_b, b4);
      chk1("R5 irq unchanged", irq, 1'b0);

      // R11 idle cycles with noisy fields
      a6 = rnd40(); b6 = rnd40();
      send_block(a6, b6, 0, 192, 0, 1);
      flush();
      chk40("R11 stat_a with gaps", stat_a, a6);
      chk40("R11 stat_b with gaps", stat_b, b6);
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

      // R10 clear and set in the same cycle
      a7 = ~a6; b7 = ~b6;
      send_block(a7, b7, 0, 192, 0, 0);
      flush();
      chk1("R10 irq set", irq, 1'b1);
      send_block(a7, ~b7, 0, 40, 1, 0);
      flush();
      chk1("R10 set wins over clear", irq, 1'b1);
      sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      flush();
      chk1("R10 plain clear", irq, 1'b0);

      // random phase against the model (R2 R3 R8 R9 R10)
      for (int it = 0; it < 20; it++) begin
         irq_en = 1'($urandom);
         send_block(rnd40(), rnd40(), ($urandom % 4 == 0) ? 1 : 0,
                    1 + ($urandom % 200), 1'($urandom), 1'($urandom));
         if ($urandom % 2 == 0) sub(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      end
      flush();
      flush();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule